// File: doc/BRIEF.md
# Four-Way Data Cache Controller

This block is a data cache that sits between a processor's load/store port and an external line-wide memory port. It holds four ways of 256 lines each. Each line is 32 bytes. The processor presents two things on every access: the set index, taken from the virtual address, and a physical word address, whose upper bits are compared against the stored tags. Hits are served from on-chip line storage. Misses move whole 32-byte lines across the memory port. Each set keeps a full least-recently-used ordering of its four ways.

Each access carries its own write-policy bit. When the bit is set, the cache uses copy-back: written lines are marked dirty, and they are written out as full lines only when they are chosen for eviction. When the bit is clear, the cache uses write-through: the word is also written to memory as a single-lane transfer, and a write miss never allocates a line.

A synchronous invalidate-all input drops the whole contents of the cache. It writes nothing back.

Both ports use a valid/ready handshake. The processor holds its request until `cpu_ready`. The cache holds its memory request until `mem_ready`. For memory reads, the line data is taken in the `mem_ready` cycle.

Top module: `dcache_sa4`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready` and `mem_valid` are low. The first access to any set misses.
- R2: Address split. The tag is `cpu_paddr[31:13]` and the word within the line is `cpu_paddr[4:2]`. A hit needs a valid way whose stored tag equals all 19 tag bits. Memory addresses are line addresses (byte address bits [31:5]). Word i of a line occupies data bits [32i+31:32i].
- R3: The set is chosen by `cpu_vindex` alone. The same physical address presented with a different `cpu_vindex` misses and fills that other set.
- R4: A read hit raises `cpu_ready` combinationally in the cycle the request is seen, returns the stored word, and makes no memory request.
- R5: A read miss issues one memory read with `mem_burst`=1, `mem_wen`=0 and the request's line address. After the line is accepted, `cpu_ready` rises in the following cycle with the requested word of the filled line.
- R6: On a miss that allocates, the victim is the lowest-numbered invalid way of the set. If all four ways are valid, the victim is the least recently used way.
- R7: Every hit and every fill makes the accessed way the most recently used in its set. The other ways keep their relative order.
- R8: A copy-back write hit stores the word, marks the line dirty, raises `cpu_ready` in the same cycle, and makes no memory request.
- R9: A dirty victim is first written out: one memory write with `mem_burst`=1, `mem_wen`=8'hFF, address {stored tag, set index} and the full line. The fill follows it. A clean victim is not written out.
- R10: A copy-back write miss allocates. It evicts if needed, fills, then writes the word into the filled line and marks the line dirty.
- R11: A write-through write hit stores the word in the line and issues one memory write with `mem_burst`=0 and `mem_wen` one-hot at bit `cpu_paddr[4:2]`, with the word in that lane. `cpu_ready` rises in the `mem_ready` cycle. The line's dirty state is left unchanged.
- R12: A write-through write miss issues the same single-lane memory write and allocates nothing. A later read of that address misses.
- R13: `inv_all`, held for one cycle with no request pending, clears every valid and dirty bit. No memory write results. Later accesses miss, and they fill without any eviction.
- R14: Once raised, `mem_valid` stays high with stable command fields until `mem_ready`. `cpu_ready` is only raised while `cpu_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Invalidate every line without write-back |
| cpu_valid | input | 1 | Processor request present; held until `cpu_ready` |
| cpu_ready | output | 1 | Request completed this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_copyback | input | 1 | 1 = copy-back, 0 = write-through for this access |
| cpu_vindex | input | 8 | Set index from virtual address bits [12:5] |
| cpu_paddr | input | 30 | Physical word address (byte address bits [31:2]) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_write | output | 1 | 1 = write, 0 = line read |
| mem_burst | output | 1 | 1 = whole-line transfer, 0 = single word lane |
| mem_addr | output | 27 | Line address (byte address bits [31:5]) |
| mem_wen | output | 8 | Per-word write enables |
| mem_wdata | output | 256 | Write data, word i in bits [32i+31:32i] |
| mem_rdata | input | 256 | Line read data |

## Verification
The bench's behavioural model predicts every memory command and every returned word. Each kind of wrong state therefore shows at the ports in its own way, and at its own time:
- A bad valid or tag bit shows up on the next access to that set, as an extra or missing fill.
- A corrupted recency order stays hidden until the set is full and misses. Then the eviction address or the fill's destination way is wrong, and a later hit turns into a miss.
- A wrong dirty bit may hide for many accesses. It only shows when that line is chosen as a victim, as a missing or spurious full-line write.

The random phase keeps traffic on two crowded sets and adds variable memory latency. This keeps that delay short and makes the stability of held commands checked on each waiting cycle.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int WAYS       = 4;
    localparam int SETS       = 256;
    localparam int LINE_BYTES = 32;
    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int WORDS   = LINE_BYTES * 8 / WORD_W;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int WADDR_W = ADDR_W - 2;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } dc_state_e;

    typedef struct packed {
        tag_t  tag;
        idx_t  pidx;
        wsel_t wsel;
    } paddr_t;

    function automatic logic [WORDS-1:0] lane_enable(input wsel_t sel);
        logic [WORDS-1:0] m;
        m = '0;
        m[sel] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/dc_tags.sv
module dc_tags
    import dcache_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            inv_all,
    input  idx_t            idx,
    input  tag_t            look_tag,
    input  way_t            sel_way,
    output logic            hit_any,
    output way_t            hit_way,
    output logic [WAYS-1:0] valid_vec,
    output logic [WAYS-1:0] dirty_vec,
    output tag_t            sel_tag,
    input  logic            fill_en,
    input  way_t            fill_way,
    input  tag_t            fill_tag,
    input  logic            dirty_en,
    input  way_t            dirty_way
);
    tag_t            tag_q   [SETS][WAYS];
    logic [WAYS-1:0] valid_q [SETS];
    logic [WAYS-1:0] dirty_q [SETS];
    logic [WAYS-1:0] hit_vec;

    assign valid_vec = valid_q[idx];
    assign dirty_vec = dirty_q[idx];
    assign sel_tag   = tag_q[idx][sel_way];

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[idx][g] && (tag_q[idx][g] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end
    assign hit_any = |hit_vec;

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx][fill_way] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            valid_q <= '{default: '0};
            dirty_q <= '{default: '0};
        end else begin
            if (fill_en) begin
                valid_q[idx][fill_way] <= 1'b1;
                dirty_q[idx][fill_way] <= 1'b0;
            end
            if (dirty_en) dirty_q[idx][dirty_way] <= 1'b1;
        end
    end

    // R2
    hit_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R13
    inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0) && (dirty_vec == '0));
endmodule

// File: rtl/dc_lru.sv
module dc_lru
    import dcache_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  idx_t            idx,
    input  logic [WAYS-1:0] valid_vec,
    input  logic            touch_en,
    input  way_t            touch_way,
    output way_t            victim
);
    way_t            age_q [SETS][WAYS];
    logic [WAYS-1:0] oldest;
    logic            any_free;
    way_t            free_way;
    way_t            old_way;

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        old_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            oldest[w] = (age_q[idx][w] == way_t'(WAYS - 1));
            if (!valid_vec[w]) begin
                any_free = 1'b1;
                free_way = way_t'(w);
            end
            if (oldest[w]) old_way = way_t'(w);
        end
        victim = any_free ? free_way : old_way;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= way_t'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_t'(w) == touch_way)
                    age_q[idx][w] <= '0;
                else if (age_q[idx][w] < age_q[idx][touch_way])
                    age_q[idx][w] <= age_q[idx][w] + 1'b1;
            end
        end
    end

    idx_t chk_idx;
    way_t chk_way;
    logic chk_vld;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_vld <= 1'b0;
            chk_idx <= '0;
            chk_way <= '0;
        end else begin
            chk_vld <= touch_en;
            chk_idx <= idx;
            chk_way <= touch_way;
        end
    end

    // R7
    mru_after_touch_chk: assert property (@(posedge clk) disable iff (rst)
        chk_vld |-> (age_q[chk_idx][chk_way] == '0));

    // R6
    single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(oldest));
endmodule

// File: rtl/dc_data.sv
module dc_data
    import dcache_pkg::*;
(
    input  logic  clk,
    input  idx_t  idx,
    input  way_t  rd_way,
    output line_t rd_line,
    input  logic  line_we,
    input  way_t  line_way,
    input  line_t line_in,
    input  logic  word_we,
    input  way_t  word_way,
    input  wsel_t word_sel,
    input  word_t word_in
);
    line_t data_q [SETS][WAYS];

    assign rd_line = data_q[idx][rd_way];

    always_ff @(posedge clk) begin
        if (line_we)
            data_q[idx][line_way] <= line_in;
        else if (word_we)
            data_q[idx][word_way][word_sel*WORD_W +: WORD_W] <= word_in;
    end
endmodule

// File: rtl/dcache_sa4.sv
module dcache_sa4
    import dcache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inv_all,
    input  logic                  cpu_valid,
    output logic                  cpu_ready,
    input  logic                  cpu_write,
    input  logic                  cpu_copyback,
    input  logic [IDX_W-1:0]      cpu_vindex,
    input  logic [ADDR_W-1:2]     cpu_paddr,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic                  mem_write,
    output logic                  mem_burst,
    output logic [ADDR_W-1:OFF_W] mem_addr,
    output logic [WORDS-1:0]      mem_wen,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic [LINE_W-1:0]     mem_rdata
);
    dc_state_e state_q, state_d;
    way_t      vic_q, vic_d;
    paddr_t    pa;

    logic            hit_any, lookup_go;
    way_t            hit_way, victim, rd_way, touch_way;
    logic [WAYS-1:0] valid_vec, dirty_vec;
    tag_t            sel_tag;
    line_t           rd_line;
    logic            touch_en, fill_en, dirty_en, word_we, line_we;

    assign pa        = paddr_t'(cpu_paddr);
    assign lookup_go = (state_q == ST_IDLE) && cpu_valid && !inv_all;
    assign rd_way    = (state_q == ST_EVICT) ? vic_q : hit_way;
    assign cpu_rdata = rd_line[pa.wsel*WORD_W +: WORD_W];

    dc_tags u_tags (
        .clk(clk), .rst(rst), .inv_all(inv_all),
        .idx(cpu_vindex), .look_tag(pa.tag), .sel_way(vic_q),
        .hit_any(hit_any), .hit_way(hit_way),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec), .sel_tag(sel_tag),
        .fill_en(fill_en), .fill_way(vic_q), .fill_tag(pa.tag),
        .dirty_en(dirty_en), .dirty_way(hit_way)
    );

    dc_lru u_lru (
        .clk(clk), .rst(rst), .idx(cpu_vindex), .valid_vec(valid_vec),
        .touch_en(touch_en), .touch_way(touch_way), .victim(victim)
    );

    dc_data u_data (
        .clk(clk), .idx(cpu_vindex), .rd_way(rd_way), .rd_line(rd_line),
        .line_we(line_we), .line_way(vic_q), .line_in(mem_rdata),
        .word_we(word_we), .word_way(hit_way), .word_sel(pa.wsel),
        .word_in(cpu_wdata)
    );

    always_comb begin
        state_d   = state_q;
        vic_d     = vic_q;
        cpu_ready = 1'b0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        fill_en   = 1'b0;
        dirty_en  = 1'b0;
        word_we   = 1'b0;
        line_we   = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_burst = 1'b0;
        mem_addr  = {pa.tag, pa.pidx};
        mem_wen   = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (lookup_go) begin
                    if (hit_any) begin
                        touch_en = 1'b1;
                        if (!cpu_write) begin
                            cpu_ready = 1'b1;
                        end else begin
                            word_we = 1'b1;
                            if (cpu_copyback) begin
                                dirty_en  = 1'b1;
                                cpu_ready = 1'b1;
                            end else begin
                                state_d = ST_WTHRU;
                            end
                        end
                    end else if (cpu_write && !cpu_copyback) begin
                        state_d = ST_WTHRU;
                    end else begin
                        vic_d   = victim;
                        state_d = (valid_vec[victim] && dirty_vec[victim])
                                  ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_burst = 1'b1;
                mem_addr  = {sel_tag, cpu_vindex};
                mem_wen   = '1;
                mem_wdata = rd_line;
                if (mem_ready) state_d = ST_FILL;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_burst = 1'b1;
                if (mem_ready) begin
                    line_we   = 1'b1;
                    fill_en   = 1'b1;
                    touch_en  = 1'b1;
                    touch_way = vic_q;
                    state_d   = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wen   = lane_enable(pa.wsel);
                mem_wdata = {WORDS{cpu_wdata}};
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vic_q   <= '0;
        end else begin
            state_q <= state_d;
            vic_q   <= vic_d;
        end
    end

    // R14
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_write) && $stable(mem_burst)));

    // R14
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_valid);

    // R9
    fill_follows_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_write && mem_burst) |=> (mem_valid && !mem_write));
endmodule

// File: tb/sim_dcache_sa4.sv
module sim_dcache_sa4;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inv_all = 1'b0;
    logic         cpu_valid = 1'b0;
    logic         cpu_ready;
    logic         cpu_write = 1'b0;
    logic         cpu_copyback = 1'b0;
    logic [7:0]   cpu_vindex = '0;
    logic [31:2]  cpu_paddr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic         mem_write, mem_burst;
    logic [31:5]  mem_addr;
    logic [7:0]   mem_wen;
    logic [255:0] mem_wdata;
    logic [255:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    int mem_lat = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dcache_sa4 u0 (
        .clk(clk), .rst(rst), .inv_all(inv_all),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_copyback(cpu_copyback), .cpu_vindex(cpu_vindex), .cpu_paddr(cpu_paddr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wen(mem_wen),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit           wr;
        bit           burst;
        logic [26:0]  la;
        logic [7:0]   wen;
        logic [255:0] data;
        logic [255:0] mask;
    } op_t;
    op_t exp_q[$];

    // behavioural model state
    bit          m_val   [256][4];
    bit          m_dirty [256][4];
    logic [18:0] m_tag   [256][4];
    logic [255:0] m_data [256][4];
    int          m_age   [256][4];
    logic [255:0] ref_mem [int unsigned];
    logic [255:0] dut_mem [int unsigned];

    function automatic logic [255:0] init_line(input logic [26:0] la);
        logic [255:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = {la[19:0], 4'(i), 8'hA5};
        return l;
    endfunction

    function automatic logic [255:0] ref_read(input logic [26:0] la);
        if (ref_mem.exists(int'(la))) return ref_mem[int'(la)];
        return init_line(la);
    endfunction

    function automatic logic [255:0] dut_read(input logic [26:0] la);
        if (dut_mem.exists(int'(la))) return dut_mem[int'(la)];
        return init_line(la);
    endfunction

    function automatic void m_touch(input int s, input int w);
        for (int v = 0; v < 4; v++)
            if (v != w && m_age[s][v] < m_age[s][w]) m_age[s][v]++;
        m_age[s][w] = 0;
    endfunction

    function automatic logic [31:2] pa_of(input int tag, input int set, input int word);
        return {19'(tag), 8'(set), 3'(word)};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic push_wthru(input logic [31:2] pa, input logic [31:0] wd);
        op_t o;
        logic [255:0] l;
        o.wr = 1; o.burst = 0; o.la = pa[31:5];
        o.wen = 8'(1) << pa[4:2];
        o.data = 256'(wd) << (pa[4:2] * 32);
        o.mask = 256'(32'hFFFF_FFFF) << (pa[4:2] * 32);
        exp_q.push_back(o);
        l = ref_read(pa[31:5]);
        l[pa[4:2]*32 +: 32] = wd;
        ref_mem[int'(pa[31:5])] = l;
    endtask

    // predict all memory traffic and the returned word of one access
    task automatic model(input bit wr, input bit cb, input logic [7:0] vi,
                         input logic [31:2] pa, input logic [31:0] wd,
                         output logic [31:0] exp_rd);
        int s, hw, v;
        op_t o;
        s = int'(vi);
        hw = -1;
        exp_rd = '0;
        for (int w = 0; w < 4; w++)
            if (m_val[s][w] && m_tag[s][w] == pa[31:13]) hw = w;
        if (hw < 0) begin
            if (wr && !cb) begin
                push_wthru(pa, wd);
            end else begin
                v = -1;
                for (int w = 3; w >= 0; w--) if (!m_val[s][w]) v = w;
                if (v < 0) for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) v = w;
                if (m_val[s][v] && m_dirty[s][v]) begin
                    o.wr = 1; o.burst = 1; o.la = {m_tag[s][v], vi};
                    o.wen = 8'hFF; o.data = m_data[s][v]; o.mask = '1;
                    exp_q.push_back(o);
                    ref_mem[int'(o.la)] = m_data[s][v];
                end
                o.wr = 0; o.burst = 1; o.la = pa[31:5]; o.wen = 8'h00;
                o.data = '0; o.mask = '0;
                exp_q.push_back(o);
                m_data[s][v] = ref_read(pa[31:5]);
                m_tag[s][v] = pa[31:13];
                m_val[s][v] = 1; m_dirty[s][v] = 0;
                m_touch(s, v);
                hw = v;
            end
        end
        if (hw >= 0) begin
            m_touch(s, hw);
            if (!wr) begin
                exp_rd = m_data[s][hw][pa[4:2]*32 +: 32];
            end else begin
                m_data[s][hw][pa[4:2]*32 +: 32] = wd;
                if (cb) m_dirty[s][hw] = 1;
                else push_wthru(pa, wd);
            end
        end
    endtask

    task automatic access(input string rq, input bit wr, input bit cb,
                          input logic [7:0] vi, input logic [31:2] pa,
                          input logic [31:0] wd);
        logic [31:0] exp_rd;
        logic [255:0] l;
        bit done, pend_ready;
        logic [255:0] pend_data;
        int cyc, wait_c;
        model(wr, cb, vi, pa, wd, exp_rd);
        @(negedge clk);
        cpu_valid = 1; cpu_write = wr; cpu_copyback = cb;
        cpu_vindex = vi; cpu_paddr = pa; cpu_wdata = wd;
        done = 0; cyc = 0; wait_c = 0; pend_data = '0;
        while (!done) begin
            #1;
            pend_ready = 0;
            if (!mem_ready && mem_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, rq, "unexpected memory request", 256'(mem_addr), '0);
                end else begin
                    op_t e;
                    e = exp_q[0];
                    check(mem_write == e.wr && mem_burst == e.burst && mem_addr == e.la
                          && mem_wen == e.wen && (mem_wdata & e.mask) == (e.data & e.mask),
                          rq, $sformatf("memory command w=%0b b=%0b en=%h (exp w=%0b b=%0b en=%h) addr",
                                        mem_write, mem_burst, mem_wen, e.wr, e.burst, e.wen),
                          {mem_addr, mem_wdata[223:0]}, {e.la, e.data[223:0]});
                    if (wait_c >= mem_lat) begin
                        void'(exp_q.pop_front());
                        pend_ready = 1;
                        wait_c = 0;
                        if (mem_write) begin
                            l = dut_read(mem_addr);
                            for (int i = 0; i < 8; i++)
                                if (mem_wen[i]) l[i*32 +: 32] = mem_wdata[i*32 +: 32];
                            dut_mem[int'(mem_addr)] = l;
                        end else begin
                            pend_data = dut_read(mem_addr);
                        end
                    end else begin
                        wait_c++;
                    end
                end
            end
            if (cpu_ready) begin
                check(exp_q.size() == 0, rq, "completion before all memory traffic",
                      256'(exp_q.size()), '0);
                if (!wr) check(cpu_rdata == exp_rd, rq, "read data", 256'(cpu_rdata), 256'(exp_rd));
                done = 1;
            end
            cyc++;
            if (cyc > 80) begin
                check(0, rq, "access timeout", 256'(cyc), '0);
                done = 1;
            end
            @(negedge clk);
            mem_ready = pend_ready;
            mem_rdata = pend_data;
            if (done) cpu_valid = 0;
        end
        exp_q.delete();
    endtask

    task automatic quiet(input string rq);
        @(negedge clk);
        #1;
        check(!cpu_ready && !mem_valid, rq, "idle outputs",
              256'({cpu_ready, mem_valid}), '0);
    endtask

    task automatic rd(input string rq, input int tag, input int set, input int word);
        access(rq, 0, 1, 8'(set), pa_of(tag, set, word), '0);
    endtask

    initial begin
        automatic logic [31:0] seed = 32'h1234_5678;
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
                m_val[s][w] = 0; m_dirty[s][w] = 0; m_age[s][w] = w;
                m_tag[s][w] = '0; m_data[s][w] = '0;
            end
        repeat (4) @(negedge clk);
        rst = 0;
        #1;
        check(!cpu_ready && !mem_valid, "R1", "reset outputs", 256'({cpu_ready, mem_valid}), '0);

        rd("R1", 1, 5, 0);                          // cold miss, fill way 0
        rd("R5", 1, 5, 3);                          // hit on filled line data
        rd("R4", 1, 5, 7);
        access("R8", 1, 1, 8'd5, pa_of(1, 5, 2), 32'hCAFE_0001);
        rd("R8", 1, 5, 2);
        rd("R6", 2, 5, 0);                          // invalid ways first
        rd("R6", 3, 5, 1);
        rd("R6", 4, 5, 2);
        rd("R7", 1, 5, 1);                          // refresh way 0
        rd("R9", 5, 5, 0);                          // clean LRU victim, no write-out
        rd("R7", 6, 5, 4);
        access("R10", 1, 1, 8'd5, pa_of(7, 5, 4), 32'h0BAD_F00D);
        rd("R10", 7, 5, 4);
        rd("R9", 8, 5, 0);                          // dirty victims written out
        rd("R9", 9, 5, 0);
        rd("R9", 10, 5, 0);
        rd("R9", 11, 5, 0);
        rd("R9", 1, 5, 2);                          // refetch written-back word
        rd("R2", 8 | (1 << 18), 5, 0);              // top tag bit alone differs

        rd("R11", 1, 9, 0);
        access("R11", 1, 0, 8'd9, pa_of(1, 9, 5), 32'h1111_2222);
        rd("R11", 1, 9, 5);
        rd("R11", 2, 9, 0);
        rd("R11", 3, 9, 0);
        rd("R11", 4, 9, 0);
        rd("R11", 5, 9, 0);                         // line stayed clean
        rd("R11", 1, 9, 5);

        access("R12", 1, 0, 8'd20, pa_of(3, 20, 6), 32'h3333_4444);
        rd("R12", 3, 20, 6);                        // miss: nothing allocated

        rd("R3", 1, 30, 0);
        access("R3", 0, 1, 8'd31, pa_of(1, 30, 0), '0);   // other set misses
        access("R3", 0, 1, 8'd31, pa_of(1, 30, 0), '0);

        access("R13", 1, 1, 8'd40, pa_of(1, 40, 0), 32'h5555_6666);
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin m_val[s][w] = 0; m_dirty[s][w] = 0; end
        quiet("R13");
        rd("R13", 1, 40, 0);                        // fill, no write-out, old data
        rd("R13", 1, 5, 2);

        for (int n = 0; n < 120; n++) begin
            int set, tag, word;
            bit wr, cb;
            seed = seed * 32'd1103515245 + 32'd12345;
            set = 3 + int'(seed[20]);
            tag = 1 + int'(seed[27:25]) % 6;
            word = int'(seed[24:22]);
            wr = seed[19];
            cb = seed[18] | seed[17];
            mem_lat = int'(seed[16:15]);
            access("R14", wr, cb, 8'(set), pa_of(tag, set, word), seed ^ 32'h00FF_F00F);
        end
        mem_lat = 0;
        quiet("R14");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule